// File: doc/BRIEF.md
# Crossbar Element Permutation Unit

This datapath rearranges the elements of a source operand under the control of an index operand. Every element position of the result looks at the index element in the same position, reads that value as an element number, and copies the source element with that number. Elements are either bytes or 4-bit nibbles, chosen per transfer by a one-bit mode input. An index that names no element of the source gives a zero element instead of wrapping. No operand value is illegal and the unit never flags an error.

The unit is meant for an integer execution pipeline with a 32-bit or 64-bit data path, chosen by `XLEN`. Operands enter through a valid/ready handshake and the result leaves through another one. `REG_OUT` selects one of two output variants. With `REG_OUT=1` the result is held in an output register for one cycle of latency. A transfer is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and `out_valid` stay frozen and no new operand is taken. With `REG_OUT=0` the result is purely combinational, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.

Top module: `perm_xbar`

## Requirements
- R1: With the mode bit at 0 (byte mode), result byte i is the source byte whose number is the value of index byte i, for every i below XLEN/8.
- R2: In byte mode, an index byte with a value of XLEN/8 or more gives result byte 0x00. All 8 bits of the index are compared, so with XLEN=32 the value 0x84 yields zero and does not select byte 0.
- R3: With the mode bit at 1 (nibble mode), result nibble i is the source nibble whose number is the value of index nibble i, for every i below XLEN/4.
- R4: In nibble mode, an index nibble of XLEN/4 or more gives result nibble 0x0. This applies to values 8 to 15 with XLEN=32. With XLEN=64 all sixteen values are in range and no nibble is zeroed.
- R5: Element 0 sits in the least significant bits of the source, the index and the result, in both modes.
- R6: With REG_OUT=1, an accepted operand's result shows on out_data with out_valid high starting the cycle after the accepting edge, and out_valid is low until then. With REG_OUT=0, out_valid equals in_valid and out_data is valid in the same cycle.
- R7: With REG_OUT=1, while out_valid is high and out_ready is low, out_valid and out_data hold their values and in_ready is low.
- R8: With REG_OUT=1, a rising edge with rst high clears out_valid and out_data to zero.
- R9: With REG_OUT=1, in_ready is high whenever out_valid is low or out_ready is high. With REG_OUT=0, in_ready equals out_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_nibble | input | 1 | Mode: 0 bytes, 1 nibbles |
| in_src | input | XLEN | Source elements |
| in_idx | input | XLEN | Index elements, one per result element |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | XLEN | Permuted result |

## Verification
A wrong select path shows as a wrong element on out_data one cycle after the accepting edge in the registered variant, or in the same cycle in the combinational one. The vectors make each lane pick a different source element, so a swapped or mis-indexed lane changes a visible byte or nibble. A truncated index comparison shows as a source element where zero belongs, which the vector with index 0x80 and 0xFF catches. Broken holding logic shows as out_data changing during a stall within one cycle of out_ready falling. A missed reset shows as out_valid still high at the first sample after the reset edge.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic {
    PERM_BYTE   = 1'b0,
    PERM_NIBBLE = 1'b1
  } perm_mode_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NIBBLE_W = 4;
endpackage

// File: rtl/perm_elem_pick.sv
// Picks one EW-bit element out of N by a full-width index; an index
// that matches no element leaves the output at zero.
module perm_elem_pick #(
  parameter int unsigned EW = 8,
  parameter int unsigned N  = 8
) (
  input  logic [N*EW-1:0] src,
  input  logic [EW-1:0]   idx,
  output logic [EW-1:0]   elem
);
  always_comb begin
    elem = '0;
    for (int j = 0; j < int'(N); j++) begin
      if (idx == EW'(j)) elem = src[j*EW +: EW];
    end
  end
endmodule

// File: rtl/perm_core.sv
// Two lane arrays (byte and nibble) share the operands; mode picks one.
module perm_core
  import perm_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  perm_mode_e      mode,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] idx,
  output logic [XLEN-1:0] res
);
  localparam int unsigned NB = XLEN / BYTE_W;
  localparam int unsigned NN = XLEN / NIBBLE_W;

  logic [XLEN-1:0] byte_res;
  logic [XLEN-1:0] nib_res;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    perm_elem_pick #(.EW(BYTE_W), .N(NB)) u_pick (
      .src  (src),
      .idx  (idx[g*BYTE_W +: BYTE_W]),
      .elem (byte_res[g*BYTE_W +: BYTE_W])
    );
  end

  for (genvar g = 0; g < NN; g++) begin : g_nib
    perm_elem_pick #(.EW(NIBBLE_W), .N(NN)) u_pick (
      .src  (src),
      .idx  (idx[g*NIBBLE_W +: NIBBLE_W]),
      .elem (nib_res[g*NIBBLE_W +: NIBBLE_W])
    );
  end

  assign res = (mode == PERM_NIBBLE) ? nib_res : byte_res;
endmodule

// File: rtl/perm_out_stage.sv
// Output handshake: a one-entry register or a straight pass.
module perm_out_stage #(
  parameter int unsigned W   = 64,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  if (REG) begin : g_reg
    logic         v_q;
    logic [W-1:0] d_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) d_q <= in_data;
      end
    end

    assign out_valid = v_q;
    assign out_data  = d_q;
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/perm_xbar.sv
module perm_xbar
  import perm_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_nibble,
  input  logic [XLEN-1:0] in_src,
  input  logic [XLEN-1:0] in_idx,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);
  perm_mode_e      mode;
  logic [XLEN-1:0] res;

  assign mode = perm_mode_e'(in_nibble);

  perm_core #(.XLEN(XLEN)) u_core (
    .mode (mode),
    .src  (in_src),
    .idx  (in_idx),
    .res  (res)
  );

  perm_out_stage #(.W(XLEN), .REG(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/perm_xbar_chk.sv
module perm_xbar_chk #(
  parameter int unsigned XLEN    = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_nibble,
  input logic [7:0]      idx_lo,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_data
);
  localparam int unsigned NB = XLEN / 8;

  if (REG_OUT) begin : g_reg
    assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_take_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

    assert_ready_when_free_R9: assert property (@(posedge clk) disable iff (rst)
      (!out_valid || out_ready) |-> in_ready);

    assert_accept_latency_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

    assert_byte_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && !in_nibble && idx_lo >= 8'(NB))
        |=> (out_data[7:0] == 8'h00));
  end else begin : g_pass
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid);

    assert_ready_follows_R9: assert property (@(posedge clk) disable iff (rst)
      in_ready == out_ready);

    assert_byte_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (!in_nibble && idx_lo >= 8'(NB)) |-> (out_data[7:0] == 8'h00));
  end
endmodule

bind perm_xbar perm_xbar_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_nibble (in_nibble),
  .idx_lo    (in_idx[7:0]),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/perm_xbar_tb.sv
`timescale 1ns/1ps
module perm_xbar_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // 64-bit registered unit
  logic        a_in_valid = 1'b0, a_in_ready, a_nib = 1'b0;
  logic [63:0] a_src = '0, a_idx = '0, a_out_data;
  logic        a_out_valid, a_out_ready = 1'b1;

  perm_xbar #(.XLEN(64), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(a_in_valid), .in_ready(a_in_ready),
    .in_nibble(a_nib), .in_src(a_src), .in_idx(a_idx),
    .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data)
  );

  // 32-bit combinational unit
  logic        b_in_valid = 1'b0, b_in_ready, b_nib = 1'b0;
  logic [31:0] b_src = '0, b_idx = '0, b_out_data;
  logic        b_out_valid, b_out_ready = 1'b1;

  perm_xbar #(.XLEN(32), .REG_OUT(1'b0)) u_dut32 (
    .clk(clk), .rst(rst), .in_valid(b_in_valid), .in_ready(b_in_ready),
    .in_nibble(b_nib), .in_src(b_src), .in_idx(b_idx),
    .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data)
  );

  localparam int NV = 6;
  localparam logic        T_NIB [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [63:0] T_SRC [NV] = '{
    64'h8877665544332211, 64'h8877665544332211, 64'h8877665544332211,
    64'hFEDCBA9876543210, 64'h0123456789ABCDEF, 64'h8877665544332211};
  localparam logic [63:0] T_IDX [NV] = '{
    64'h0001020304050607, 64'h0000000000000000, 64'hFF08800706050403,
    64'h0123456789ABCDEF, 64'h0000000000000000, 64'h0001020304050607};
  localparam logic [63:0] T_EXP [NV] = '{
    64'h1122334455667788, 64'h1111111111111111, 64'h0000008877665544,
    64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF, 64'h1111121213131414};
  localparam string T_REQ [NV] = '{"R1", "R1", "R2", "R3", "R5", "R5"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_a(input logic nib, input logic [63:0] s, input logic [63:0] i);
    a_nib = nib; a_src = s; a_idx = i; a_in_valid = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 reset valid", 64'(a_out_valid), 64'd0);
    chk("R8 reset data", a_out_data, 64'd0);
    rst = 1'b0;

    // table walk, one transfer per cycle
    for (int k = 0; k < NV; k++) begin
      drive_a(T_NIB[k], T_SRC[k], T_IDX[k]);
      @(negedge clk);
      chk({T_REQ[k], " table"}, a_out_data, T_EXP[k]);
      chk("R6 valid", 64'(a_out_valid), 64'd1);
    end

    // R4: 64-bit nibble mode, every index value in range
    drive_a(1'b1, 64'hFEDCBA9876543210, 64'hFFFFFFFFFFFFFFFF);
    @(negedge clk);
    chk("R4 all-F", a_out_data, 64'hFFFFFFFFFFFFFFFF);

    // R6 latency from empty
    a_in_valid = 1'b0;
    @(negedge clk);
    chk("R6 drained", 64'(a_out_valid), 64'd0);
    drive_a(T_NIB[0], T_SRC[0], T_IDX[0]);
    #1 chk("R6 not same cycle", 64'(a_out_valid), 64'd0);
    @(negedge clk);
    chk("R6 one later valid", 64'(a_out_valid), 64'd1);
    chk("R6 one later data", a_out_data, T_EXP[0]);

    // R7 back-pressure: offer vector 2 while consumer stalls
    a_out_ready = 1'b0;
    drive_a(T_NIB[2], T_SRC[2], T_IDX[2]);
    for (int c = 0; c < 3; c++) begin
      #1 chk("R7 in_ready low", 64'(a_in_ready), 64'd0);
      @(negedge clk);
      chk("R7 held data", a_out_data, T_EXP[0]);
      chk("R7 held valid", 64'(a_out_valid), 64'd1);
    end
    a_out_ready = 1'b1;
    #1 chk("R9 ready on drain", 64'(a_in_ready), 64'd1);
    @(negedge clk);
    chk("R7 released", a_out_data, T_EXP[2]);

    // R8 reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    chk("R8 valid cleared", 64'(a_out_valid), 64'd0);
    chk("R8 data cleared", a_out_data, 64'd0);
    rst = 1'b0;
    a_in_valid = 1'b0;
    @(negedge clk);
    chk("R9 ready when empty", 64'(a_in_ready), 64'd1);

    // 32-bit combinational unit
    b_in_valid = 1'b1; b_nib = 1'b0;
    b_src = 32'h44332211; b_idx = 32'h84040300;
    #1 chk("R2 no truncation", 64'(b_out_data), 64'h00004411);
    chk("R6 comb valid", 64'(b_out_valid), 64'd1);
    b_nib = 1'b1; b_src = 32'h76543210; b_idx = 32'hF8076231;
    #1 chk("R4 nibble zero 32", 64'(b_out_data), 64'h00076231);
    b_nib = 1'b0; b_src = 32'hDDCCBBAA; b_idx = 32'h00010203;
    #1 chk("R5 byte reverse 32", 64'(b_out_data), 64'hAABBCCDD);
    b_out_ready = 1'b0; b_in_valid = 1'b0;
    #1 chk("R9 comb ready", 64'(b_in_ready), 64'd0);
    chk("R6 comb valid low", 64'(b_out_valid), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule